// File: doc/BRIEF.md
# Effective Address Unit

This unit turns the addressing mode and operand bytes of one instruction into the memory address the instruction works on. It serves an 8-bit processor with a 16-bit address space. The caller presents a mode code, the low and high operand bytes, the two index registers and the program counter of the opcode, then pulses a start strobe. Most modes resolve in the next cycle. The three pointer modes read two bytes from memory first. They use a one-outstanding request/valid port, and they finish once the second byte arrives.

The unit reports completion with a one-cycle done strobe. On that strobe it presents the effective address, a flag saying whether an address was produced, and a page-cross flag for indexed modes that carry into the high byte. For immediate operands it returns the operand byte on a separate output. It does not decode opcodes and holds no processor state.

Top module: `eag_unit`

## Requirements
- R1: Mode 3 (zero page) gives address {0x00, low operand}, with address-valid high, on the done strobe one cycle after start.
- R2: Modes 4 and 5 add X (mode 4) or Y (mode 5) to the low operand modulo 256. The high byte stays 0x00, so 0x80 plus 0xFF gives 0x007F.
- R3: Mode 6 (relative) gives program counter + 2 + the low operand read as a signed byte, computed modulo 65536.
- R4: Mode 7 gives {high, low}. Modes 8 and 9 add X or Y to that 16-bit value with carry. Page-cross is high exactly when the result's high byte differs from the operand's high byte, and it is low in every other mode.
- R5: Mode 10 reads the low pointer byte at {high, low} and then the high byte at {high, low} + 1, using the full 16-bit increment. The pointer is the address.
- R6: Mode 11 reads the pointer's low byte at zero-page location (low + X) mod 256 and its high byte at the next zero-page location, wrapping from 0xFF to 0x00.
- R7: Mode 12 reads the pointer at zero-page location low and then at (low + 1) mod 256. It adds Y to the 16-bit pointer with carry and sets page-cross as in R4.
- R8: Modes 0, 1 and 2, and the unused codes 13 to 15, finish one cycle after start with address-valid low and address 0. Mode 2 returns the low operand on the immediate output, and every other mode returns 0 there.
- R9: A read request stays high with its address unchanged until valid is seen. Each pointer mode issues exactly two reads, one at a time, and the request is high only while the unit is busy.
- R10: A start pulse that arrives while busy is ignored. The running operation completes with its own result, and no extra done strobe follows.
- R11: In reset, and after it, done, address-valid, page-cross, busy and read request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation (taken when idle) |
| mode_i | input | 4 | Addressing mode code |
| opd_lo_i | input | 8 | First operand byte |
| opd_hi_i | input | 8 | Second operand byte |
| idx_x_i | input | 8 | X index value |
| idx_y_i | input | 8 | Y index value |
| pc_i | input | 16 | Address of the instruction's opcode |
| busy_o | output | 1 | Pointer fetch in progress |
| done_o | output | 1 | One-cycle completion strobe |
| addr_vld_o | output | 1 | Result carries a memory address |
| addr_o | output | 16 | Effective address |
| page_cross_o | output | 1 | Index addition changed the high byte |
| imm_o | output | 8 | Immediate operand byte |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 16 | Memory read address |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |

## Verification
A wrong fetch state shows at the read port first. The wrong address is driven while the request is high, or the request drops before valid. After the valid that ends the second read, the first cycle carries a pointer assembled from the wrong bytes, or no done strobe at all. Faults in the direct path show at the done strobe one cycle after start, as a wrong address or flag. A start that leaks into a busy fetch shows as a second strobe or as a result that belongs to the other mode.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_IMP  = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_REL  = 4'd6,
    AM_ABS  = 4'd7,
    AM_ABSX = 4'd8,
    AM_ABSY = 4'd9,
    AM_IND  = 4'd10,
    AM_IZX  = 4'd11,
    AM_IZY  = 4'd12
  } amode_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2
  } fstate_e;
endpackage

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BR_STEP = 2,
  localparam int AW     = 2 * DW
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ea_o,
  output logic          ea_vld_o,
  output logic          xpage_o,
  output logic          ind_o,
  output logic [AW-1:0] ptr_o,
  output logic          ptr_wrap_o,
  output logic          ptr_addy_o,
  output logic [DW-1:0] imm_o
);
  localparam logic [DW-1:0] ZHI = '0;

  logic [AW-1:0] base;
  logic [AW-1:0] abs_x, abs_y, rel_t;
  logic [DW-1:0] zp_x, zp_y;

  assign base  = {hi_i, lo_i};
  assign zp_x  = lo_i + x_i;
  assign zp_y  = lo_i + y_i;
  assign abs_x = base + {ZHI, x_i};
  assign abs_y = base + {ZHI, y_i};
  assign rel_t = pc_i + AW'(BR_STEP) + {{DW{lo_i[DW-1]}}, lo_i};

  always_comb begin
    ea_o       = '0;
    ea_vld_o   = 1'b0;
    xpage_o    = 1'b0;
    ind_o      = 1'b0;
    ptr_o      = '0;
    ptr_wrap_o = 1'b1;
    ptr_addy_o = 1'b0;
    imm_o      = '0;
    case (amode_e'(mode_i))
      AM_IMM:  imm_o = lo_i;
      AM_ZP:   begin ea_o = {ZHI, lo_i}; ea_vld_o = 1'b1; end
      AM_ZPX:  begin ea_o = {ZHI, zp_x}; ea_vld_o = 1'b1; end
      AM_ZPY:  begin ea_o = {ZHI, zp_y}; ea_vld_o = 1'b1; end
      AM_REL:  begin ea_o = rel_t;       ea_vld_o = 1'b1; end
      AM_ABS:  begin ea_o = base;        ea_vld_o = 1'b1; end
      AM_ABSX: begin
        ea_o = abs_x; ea_vld_o = 1'b1;
        xpage_o = (abs_x[AW-1:DW] != hi_i);
      end
      AM_ABSY: begin
        ea_o = abs_y; ea_vld_o = 1'b1;
        xpage_o = (abs_y[AW-1:DW] != hi_i);
      end
      AM_IND:  begin ind_o = 1'b1; ptr_o = base; ptr_wrap_o = 1'b0; end
      AM_IZX:  begin ind_o = 1'b1; ptr_o = {ZHI, zp_x}; end
      AM_IZY:  begin ind_o = 1'b1; ptr_o = {ZHI, lo_i}; ptr_addy_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_fetch.sv
module eag_fetch
  import eag_pkg::*;
#(
  parameter int DW  = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wrap_i,
  input  logic          addy_i,
  input  logic [DW-1:0] y_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          fin_o,
  output logic [AW-1:0] fin_ea_o,
  output logic          fin_xpage_o
);
  localparam logic [DW-1:0] ZHI = '0;

  fstate_e       st_q;
  logic [AW-1:0] ptr_q;
  logic          wrap_q, addy_q;
  logic [DW-1:0] y_q, lo_q;
  logic [AW-1:0] ptr_hi_a, ptr_full;

  // high pointer byte: stay inside zero page for the zero-page pointer modes
  assign ptr_hi_a = wrap_q ? {ZHI, ptr_q[DW-1:0] + DW'(1)} : ptr_q + AW'(1);
  assign ptr_full = {rd_data_i, lo_q};

  assign busy_o    = (st_q != F_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = (st_q == F_HI) ? ptr_hi_a : ptr_q;

  assign fin_o       = (st_q == F_HI) && rd_vld_i;
  assign fin_ea_o    = addy_q ? ptr_full + {ZHI, y_q} : ptr_full;
  assign fin_xpage_o = addy_q && (fin_ea_o[AW-1:DW] != rd_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      ptr_q  <= '0;
      wrap_q <= 1'b0;
      addy_q <= 1'b0;
      y_q    <= '0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (go_i) begin
          st_q   <= F_LO;
          ptr_q  <= ptr_i;
          wrap_q <= wrap_i;
          addy_q <= addy_i;
          y_q    <= y_i;
        end
        F_LO: if (rd_vld_i) begin
          lo_q <= rd_data_i;
          st_q <= F_HI;
        end
        F_HI: if (rd_vld_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BR_STEP = 2,
  localparam int AW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] opd_lo_i,
  input  logic [DW-1:0] opd_hi_i,
  input  logic [DW-1:0] idx_x_i,
  input  logic [DW-1:0] idx_y_i,
  input  logic [AW-1:0] pc_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          addr_vld_o,
  output logic [AW-1:0] addr_o,
  output logic          page_cross_o,
  output logic [DW-1:0] imm_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i
);
  logic [AW-1:0] c_ea, c_ptr, f_ea;
  logic          c_vld, c_xpage, c_ind, c_wrap, c_addy;
  logic [DW-1:0] c_imm;
  logic          f_busy, f_fin, f_xpage;
  logic          accept;

  logic          done_q, vld_q, xpage_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] imm_q;

  assign accept = start_i && !f_busy;

  eag_calc #(.DW(DW), .BR_STEP(BR_STEP)) u_calc (
    .mode_i     (mode_i),
    .lo_i       (opd_lo_i),
    .hi_i       (opd_hi_i),
    .x_i        (idx_x_i),
    .y_i        (idx_y_i),
    .pc_i       (pc_i),
    .ea_o       (c_ea),
    .ea_vld_o   (c_vld),
    .xpage_o    (c_xpage),
    .ind_o      (c_ind),
    .ptr_o      (c_ptr),
    .ptr_wrap_o (c_wrap),
    .ptr_addy_o (c_addy),
    .imm_o      (c_imm)
  );

  eag_fetch #(.DW(DW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (accept && c_ind),
    .ptr_i       (c_ptr),
    .wrap_i      (c_wrap),
    .addy_i      (c_addy),
    .y_i         (idx_y_i),
    .busy_o      (f_busy),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_vld_i    (rd_vld_i),
    .rd_data_i   (rd_data_i),
    .fin_o       (f_fin),
    .fin_ea_o    (f_ea),
    .fin_xpage_o (f_xpage)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
      xpage_q <= 1'b0;
      addr_q  <= '0;
      imm_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && !c_ind) begin
        done_q  <= 1'b1;
        vld_q   <= c_vld;
        xpage_q <= c_xpage;
        addr_q  <= c_ea;
        imm_q   <= c_imm;
      end else if (f_fin) begin
        done_q  <= 1'b1;
        vld_q   <= 1'b1;
        xpage_q <= f_xpage;
        addr_q  <= f_ea;
        imm_q   <= '0;
      end
    end
  end

  assign busy_o       = f_busy;
  assign done_o       = done_q;
  assign addr_vld_o   = vld_q;
  assign addr_o       = addr_q;
  assign page_cross_o = xpage_q;
  assign imm_o        = imm_q;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int DW  = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [DW-1:0] opd_lo_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          addr_vld_o,
  input logic [AW-1:0] addr_o,
  input logic          page_cross_o,
  input logic [DW-1:0] imm_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_vld_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_hold_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_vld_i |=> rd_req_o && $stable(rd_addr_o));

  p_req_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_zp_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(start_i && !busy_o && (mode_i inside {4'd3, 4'd4, 4'd5}))
    |-> done_o && addr_vld_o && (addr_o[AW-1:DW] == '0));

  p_noaddr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(start_i && !busy_o && (mode_i inside {4'd0, 4'd1, 4'd2}))
    |-> done_o && !addr_vld_o && !page_cross_o);

  p_imm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(start_i && !busy_o && mode_i == 4'd2)
    |-> imm_o == $past(opd_lo_i));

  p_xpage_vld_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_cross_o |-> addr_vld_o);
endmodule

bind eag_unit eag_unit_chk u_chk (.*);

// File: tb/eag_unit_test.sv
module eag_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 20;
  localparam int  WDOG = 100000;

  // mode, lo, hi, x, y, pc, exp_addr, exp_vld, exp_xpage, read0, read1
  localparam logic [101:0] VEC [NV] = '{
    {4'd3,  8'h45, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0045, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd4,  8'h80, 8'h00, 8'h0F, 8'h00, 16'h0000, 16'h008F, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd4,  8'h80, 8'h00, 8'hFF, 8'h00, 16'h0000, 16'h007F, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd5,  8'hF0, 8'h00, 8'h00, 8'h20, 16'h0000, 16'h0010, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd6,  8'h05, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h1007, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd6,  8'h80, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0F82, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd6,  8'h7F, 8'h00, 8'h00, 8'h00, 16'h10F0, 16'h1171, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd7,  8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, 16'h1234, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd8,  8'h00, 8'h20, 8'h92, 8'h00, 16'h0000, 16'h2092, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {4'd8,  8'hF0, 8'h20, 8'h20, 8'h00, 16'h0000, 16'h2110, 1'b1, 1'b1, 16'h0000, 16'h0000},
    {4'd9,  8'hFF, 8'hFF, 8'h00, 8'h01, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h0000, 16'h0000},
    {4'd10, 8'h20, 8'h01, 8'h00, 8'h00, 16'h0000, 16'hBAFC, 1'b1, 1'b0, 16'h0120, 16'h0121},
    {4'd10, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0000, 16'h4000, 1'b1, 1'b0, 16'h12FF, 16'h1300},
    {4'd11, 8'h80, 8'h00, 8'hFF, 8'h00, 16'h0000, 16'h1234, 1'b1, 1'b0, 16'h007F, 16'h0080},
    {4'd11, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000, 16'h5678, 1'b1, 1'b0, 16'h00FF, 16'h0000},
    {4'd12, 8'h40, 8'h00, 8'h00, 8'h25, 16'h0000, 16'h2115, 1'b1, 1'b1, 16'h0040, 16'h0041},
    {4'd12, 8'hFF, 8'h00, 8'h00, 8'h10, 16'h0000, 16'h5688, 1'b1, 1'b0, 16'h00FF, 16'h0000},
    {4'd0,  8'h11, 8'h22, 8'h33, 8'h44, 16'h5555, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {4'd1,  8'h11, 8'h22, 8'h33, 8'h44, 16'h5555, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {4'd2,  8'hA7, 8'h22, 8'h33, 8'h44, 16'h5555, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  lo = '0, hi = '0, ix = '0, iy = '0;
  logic [15:0] pc = '0;
  logic        busy, done, avld, xpage, rd_req;
  logic [15:0] addr, rd_addr;
  logic [7:0]  imm;
  logic        rd_vld = 1'b0;
  logic [7:0]  rd_data = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int lat = 0, wcnt = 0, nreads = 0, stab_err = 0;
  logic [15:0] ra0, ra1, req_a;
  bit finished = 0;

  eag_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .opd_lo_i(lo), .opd_hi_i(hi), .idx_x_i(ix), .idx_y_i(iy), .pc_i(pc),
    .busy_o(busy), .done_o(done), .addr_vld_o(avld), .addr_o(addr),
    .page_cross_o(xpage), .imm_o(imm), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_vld_i(rd_vld), .rd_data_i(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    case (a)
      16'h0120: return 8'hFC;
      16'h0121: return 8'hBA;
      16'h12FF: return 8'h00;
      16'h1300: return 8'h40;
      16'h007F: return 8'h34;
      16'h0080: return 8'h12;
      16'h00FF: return 8'h78;
      16'h0000: return 8'h56;
      16'h0040: return 8'hF0;
      16'h0041: return 8'h20;
      default:  return 8'hEE;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd3: return "R1";
      4'd4, 4'd5: return "R2";
      4'd6: return "R3";
      4'd7, 4'd8, 4'd9: return "R4";
      4'd10: return "R5";
      4'd11: return "R6";
      4'd12: return "R7";
      default: return "R8";
    endcase
  endfunction

  // memory model: answers after lat waiting cycles
  always @(negedge clk) begin
    if (rd_vld) begin
      rd_vld = 1'b0;
      wcnt = 0;
    end else if (rd_req) begin
      if (wcnt == 0) req_a = rd_addr;
      else if (rd_addr !== req_a) stab_err++;
      if (wcnt >= lat) begin
        rd_vld = 1'b1;
        rd_data = mem_rd(rd_addr);
        if (nreads == 0) ra0 = rd_addr;
        if (nreads == 1) ra1 = rd_addr;
        nreads++;
      end else wcnt++;
    end
  end

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [7:0] l, input logic [7:0] h,
                        input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                        output int ncyc);
    @(negedge clk);
    mode = m; lo = l; hi = h; ix = x; iy = y; pc = p; start = 1'b1; nreads = 0;
    @(negedge clk);
    start = 1'b0;
    ncyc = 0;
    while (!done && ncyc < 300) begin
      @(negedge clk);
      ncyc++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
      summary();
    end
  end

  initial begin
    int nc;
    int ndone;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11", "done in reset", done, 0);
    check("R11", "addr_vld in reset", avld, 0);
    check("R11", "busy/req in reset", {busy, rd_req, xpage}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after reset", {done, avld, busy, rd_req, xpage}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      string rq;
      v = VEC[i];
      rq = req_of(v[101:98]);
      run_op(v[101:98], v[97:90], v[89:82], v[81:74], v[73:66], v[65:50], nc);
      check(rq, $sformatf("vec%0d done", i), done, 1);
      check(rq, $sformatf("vec%0d addr", i), addr, v[49:34]);
      check(rq, $sformatf("vec%0d addr_vld", i), avld, v[33]);
      check(rq, $sformatf("vec%0d page_cross", i), xpage, v[32]);
      if (v[101:98] >= 4'd10 && v[101:98] <= 4'd12) begin
        check("R9", $sformatf("vec%0d read count", i), nreads, 2);
        check(rq, $sformatf("vec%0d first read", i), ra0, v[31:16]);
        check(rq, $sformatf("vec%0d second read", i), ra1, v[15:0]);
      end else begin
        check(rq, $sformatf("vec%0d one-cycle latency", i), nc, 0);
        check(rq, $sformatf("vec%0d no reads", i), nreads, 0);
        check("R8", $sformatf("vec%0d imm", i), imm, (v[101:98] == 4'd2) ? v[97:90] : 8'h00);
      end
    end

    // R8 unused code behaves as implied
    run_op(4'd14, 8'h99, 8'h88, 8'h01, 8'h01, 16'h4000, nc);
    check("R8", "unused code addr_vld", avld, 0);
    check("R8", "unused code addr", addr, 0);

    // R9 slow memory: request held, result unchanged
    lat = 3; stab_err = 0;
    run_op(4'd12, 8'h40, 8'h00, 8'h00, 8'hC0, 16'h0000, nc);
    check("R7", "slow izy addr", addr, 16'h21B0);
    check("R7", "slow izy page_cross", xpage, 1);
    check("R9", "request address stable", stab_err, 0);
    check("R9", "slow read count", nreads, 2);
    check("R9", "slow op length", nc >= 8, 1);

    // R10 start while busy ignored
    lat = 4;
    @(negedge clk);
    mode = 4'd10; lo = 8'h20; hi = 8'h01; start = 1'b1; nreads = 0;
    @(negedge clk);
    mode = 4'd3; lo = 8'h33; hi = 8'h00; start = 1'b1;
    check("R10", "busy during fetch", busy, 1);
    @(negedge clk);
    start = 1'b0;
    check("R10", "no done from ignored start", done, 0);
    ndone = 0; nc = 0;
    while (!done && nc < 300) begin @(negedge clk); nc++; end
    check("R10", "busy result addr", addr, 16'hBAFC);
    check("R10", "busy result reads", nreads, 2);
    repeat (4) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check("R10", "no extra done", ndone, 0);
    lat = 0;

    // R11 reset mid-fetch
    lat = 5;
    @(negedge clk);
    mode = 4'd11; lo = 8'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11", "async reset clears", {done, avld, busy, rd_req, xpage}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    lat = 0;
    repeat (2) @(negedge clk);
    check("R11", "idle after second reset", {busy, rd_req}, 0);

    summary();
  end
endmodule